// File: doc/BRIEF.md
# Memory Write Error Injector

This block sits on the write path of a single memory channel and deliberately corrupts writes so that error detection and correction logic downstream can be exercised. On every write strobe it compares the decoded DRAM address (DIMM, rank, bank, page, column) against a programmed pattern. Each field of the pattern can be compared or skipped. When an armed unit sees a matching write, it inverts selected ECC check bits in one or both 32-byte halves of the line, raises an address-parity corruption flag, or does both.

Software programs it through a small register write port. Three staging registers hold the address-match word, the per-field compare enables and the ECC flip mask. A control word sets the kind of error, the target halves and the repeat behaviour. Staged values are copied into the active set only when the control word is written with an error type enabled. Writing zero to the control word disarms the unit. In one-shot mode the unit corrupts a single write and then disarms itself. In repeat mode it corrupts every matching write until software clears the control word.

Top module: `wrErrInjector`

## Requirements
- R1: After synchronous reset the unit is disarmed (`armedOut`=0), `outValid` and `parityBad` are 0, the ECC outputs are 0, and all five field compare enables are 0, so every field is ignored.
- R2: The register port decodes `regSel` as 0 = match word, 1 = compare enables, 2 = ECC flip mask, 3 = control word. A control write with bit 3 (ECC error) or bit 4 (parity error) set makes `armedOut` 1 from the next cycle. A control write of zero makes it 0 from the next cycle.
- R3: With all compare enables 0, any write matches, whatever its address.
- R4: Compare enable bit 0 covers the column (match bits 13:0), bit 1 covers the page (bits 29:14) and bit 2 covers the bank (bits 33:30). A write that differs from the pattern in an enabled field is not corrupted. A difference in a disabled field is ignored.
- R5: Enable bit 3 covers the rank and bit 4 covers the DIMM. When `threeDimm` is 1, the DIMM is compared against match bits 36:35 and the rank bit 0 against bit 34. When `threeDimm` is 0, DIMM bit 0 is compared against bit 36 and the 2-bit rank against bits 35:34.
- R6: Control bits 2:1 select the half: bit 1 targets the lower half (`eccLoIn`), bit 2 targets the upper half (`eccHiIn`), 3 targets both and 0 targets neither.
- R7: On an injected write with control bit 3 set, each targeted half's output equals its input XOR the active flip mask. An untargeted half, and every write without injection, passes through unchanged.
- R8: With control bit 4 set, an injected write raises `parityBad` together with its output. Otherwise `parityBad` is 0.
- R9: When control bit 0 (repeat) is 0, exactly one matching write is corrupted and `armedOut` then reads 0.
- R10: When control bit 0 is 1, every matching write is corrupted and `armedOut` stays 1 until the control word is cleared.
- R11: Writes to the match word, the compare enables or the flip mask do not change injection until the next arming control write.
- R12: Outputs are registered: a write presented with `wrStrobe` shows up one cycle later with `outValid`=1. Cycles without a strobe neither inject nor consume a one-shot arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWe | input | 1 | Register write enable |
| regSel | input | 2 | Register select |
| regWdata | input | REG_W (37) | Register write data |
| threeDimm | input | 1 | Channel carries more than two DIMMs |
| wrStrobe | input | 1 | Memory write strobe |
| wrDimm | input | 2 | Decoded DIMM of the write |
| wrRank | input | 2 | Decoded rank |
| wrBank | input | BANK_W (4) | Decoded bank |
| wrPage | input | PAGE_W (16) | Decoded page/row |
| wrCol | input | COL_W (14) | Decoded column |
| eccLoIn | input | ECC_W (32) | Check bits, lower half-line |
| eccHiIn | input | ECC_W (32) | Check bits, upper half-line |
| eccLoOut | output | ECC_W (32) | Possibly corrupted lower check bits |
| eccHiOut | output | ECC_W (32) | Possibly corrupted upper check bits |
| parityBad | output | 1 | Address-parity corruption flag |
| outValid | output | 1 | Output belongs to a write one cycle earlier |
| armedOut | output | 1 | Injection armed status |

## Verification
The match logic is tried first with every field ignored, then with column, page and bank enabled while one field at a time is varied, so that each field's comparator is shown to be distinct. A rank change is also made while rank is ignored. The DIMM/rank split is driven with the same address under both `threeDimm` values, so a swapped bit layout gives a hit where a miss is expected. ECC masks that stay inside one 16-bit pair and masks that span several pairs are applied to lower, upper, both and neither halves. One-shot and repeat runs, idle cycles between arming and the first write, and flip-mask rewrites while armed separate disarming and staging faults from datapath faults.

// File: rtl/injPkg.sv
package injPkg;

  // register port selects
  typedef enum logic [1:0] {
    SEL_MATCH = 2'd0,
    SEL_CARE  = 2'd1,
    SEL_FLIP  = 2'd2,
    SEL_CTRL  = 2'd3
  } regSel_e;

  // control word bit positions
  localparam int CTL_REPEAT = 0;
  localparam int CTL_LO     = 1;
  localparam int CTL_HI     = 2;
  localparam int CTL_ECC    = 3;
  localparam int CTL_PAR    = 4;
  localparam int CTL_W      = 5;

  // compare-enable bit positions
  localparam int FLD_COL   = 0;
  localparam int FLD_PAGE  = 1;
  localparam int FLD_BANK  = 2;
  localparam int FLD_RANK  = 3;
  localparam int FLD_DIMM  = 4;
  localparam int NUM_FLD   = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic flipLo;
    logic flipHi;
    logic parity;
  } injCmd_t;

endpackage

// File: rtl/addrMatcher.sv
module addrMatcher
  import injPkg::*;
#(
  parameter int COL_W  = 14,
  parameter int PAGE_W = 16,
  parameter int BANK_W = 4,
  localparam int MATCH_W = COL_W + PAGE_W + BANK_W + 3
) (
  input  logic [MATCH_W-1:0] matchWord,
  input  logic [NUM_FLD-1:0] care,
  input  logic               threeDimm,
  input  logic [1:0]         dimm,
  input  logic [1:0]         rank,
  input  logic [BANK_W-1:0]  bank,
  input  logic [PAGE_W-1:0]  page,
  input  logic [COL_W-1:0]   col,
  output logic               hit
);

  localparam int PAGE_LSB = COL_W;
  localparam int BANK_LSB = PAGE_LSB + PAGE_W;
  localparam int RANK_LSB = BANK_LSB + BANK_W;

  logic [NUM_FLD-1:0] fieldEq;
  logic [NUM_FLD-1:0] fieldOk;

  always_comb begin
    fieldEq[FLD_COL]  = (matchWord[COL_W-1:0] == col);
    fieldEq[FLD_PAGE] = (matchWord[PAGE_LSB +: PAGE_W] == page);
    fieldEq[FLD_BANK] = (matchWord[BANK_LSB +: BANK_W] == bank);
    if (threeDimm) begin
      fieldEq[FLD_RANK] = (matchWord[RANK_LSB] == rank[0]);
      fieldEq[FLD_DIMM] = (matchWord[RANK_LSB+1 +: 2] == dimm);
    end else begin
      fieldEq[FLD_RANK] = (matchWord[RANK_LSB +: 2] == rank);
      fieldEq[FLD_DIMM] = (matchWord[RANK_LSB+2] == dimm[0]);
    end
  end

  // a field passes when it matches or is not compared
  for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
    assign fieldOk[f] = fieldEq[f] | ~care[f];
  end

  assign hit = &fieldOk;

endmodule

// File: rtl/injCtrl.sv
module injCtrl
  import injPkg::*;
#(
  parameter int MATCH_W = 37,
  parameter int ECC_W   = 32,
  parameter int REG_W   = 37
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               regWe,
  input  logic [1:0]         regSel,
  input  logic [REG_W-1:0]   regWdata,
  input  logic               wrStrobe,
  input  logic               hit,
  output logic [MATCH_W-1:0] actMatch,
  output logic [NUM_FLD-1:0] actCare,
  output logic [ECC_W-1:0]   actFlip,
  output logic               armed,
  output injCmd_t            cmd
);

  logic [MATCH_W-1:0] stgMatch;
  logic [NUM_FLD-1:0] stgCare;
  logic [ECC_W-1:0]   stgFlip;
  logic [CTL_W-1:0]   ctrlWord;
  logic               ctrlWrite;
  logic               armWrite;
  logic               fire;

  assign ctrlWrite = regWe && (regSel == SEL_CTRL);
  assign armWrite  = ctrlWrite && (regWdata[CTL_ECC] || regWdata[CTL_PAR]);
  assign fire      = armed && wrStrobe && hit;

  always_comb begin
    cmd.flipLo = fire && ctrlWord[CTL_ECC] && ctrlWord[CTL_LO];
    cmd.flipHi = fire && ctrlWord[CTL_ECC] && ctrlWord[CTL_HI];
    cmd.parity = fire && ctrlWord[CTL_PAR];
  end

  // staging registers
  always_ff @(posedge clk) begin
    if (rst) begin
      stgMatch <= '0;
      stgCare  <= '0;
      stgFlip  <= '0;
    end else if (regWe) begin
      case (regSel)
        SEL_MATCH: stgMatch <= regWdata[MATCH_W-1:0];
        SEL_CARE:  stgCare  <= regWdata[NUM_FLD-1:0];
        SEL_FLIP:  stgFlip  <= regWdata[ECC_W-1:0];
        default:   ;
      endcase
    end
  end

  // active copy, loaded only when arming
  always_ff @(posedge clk) begin
    if (rst) begin
      actMatch <= '0;
      actCare  <= '0;
      actFlip  <= '0;
    end else if (armWrite) begin
      actMatch <= stgMatch;
      actCare  <= stgCare;
      actFlip  <= stgFlip;
    end
  end

  // control word and arm state
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlWord <= '0;
      armed    <= 1'b0;
    end else if (ctrlWrite) begin
      ctrlWord <= regWdata[CTL_W-1:0];
      armed    <= armWrite;
    end else if (fire && !ctrlWord[CTL_REPEAT]) begin
      armed    <= 1'b0;
    end
  end

endmodule

// File: rtl/injDatapath.sv
module injDatapath
  import injPkg::*;
#(
  parameter int ECC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrStrobe,
  input  injCmd_t          cmd,
  input  logic [ECC_W-1:0] flipMask,
  input  logic [ECC_W-1:0] eccLoIn,
  input  logic [ECC_W-1:0] eccHiIn,
  output logic [ECC_W-1:0] eccLoOut,
  output logic [ECC_W-1:0] eccHiOut,
  output logic             parityBad,
  output logic             outValid
);

  localparam int HALVES = 2;

  logic [HALVES-1:0][ECC_W-1:0] eccIn;
  logic [HALVES-1:0][ECC_W-1:0] eccQ;
  logic [HALVES-1:0]            halfSel;

  assign eccIn   = {eccHiIn, eccLoIn};
  assign halfSel = {cmd.flipHi, cmd.flipLo};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst) begin
        eccQ[h] <= '0;
      end else begin
        eccQ[h] <= eccIn[h] ^ (halfSel[h] ? flipMask : '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      parityBad <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      parityBad <= cmd.parity;
      outValid  <= wrStrobe;
    end
  end

  assign eccLoOut = eccQ[0];
  assign eccHiOut = eccQ[1];

endmodule

// File: rtl/wrErrInjector.sv
module wrErrInjector
  import injPkg::*;
#(
  parameter int COL_W  = 14,
  parameter int PAGE_W = 16,
  parameter int BANK_W = 4,
  parameter int ECC_W  = 32,
  localparam int MATCH_W = COL_W + PAGE_W + BANK_W + 3,
  localparam int REG_W   = (MATCH_W > ECC_W) ? MATCH_W : ECC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              threeDimm,
  input  logic              wrStrobe,
  input  logic [1:0]        wrDimm,
  input  logic [1:0]        wrRank,
  input  logic [BANK_W-1:0] wrBank,
  input  logic [PAGE_W-1:0] wrPage,
  input  logic [COL_W-1:0]  wrCol,
  input  logic [ECC_W-1:0]  eccLoIn,
  input  logic [ECC_W-1:0]  eccHiIn,
  output logic [ECC_W-1:0]  eccLoOut,
  output logic [ECC_W-1:0]  eccHiOut,
  output logic              parityBad,
  output logic              outValid,
  output logic              armedOut
);

  logic [MATCH_W-1:0] actMatch;
  logic [NUM_FLD-1:0] actCare;
  logic [ECC_W-1:0]   actFlip;
  logic               hit;
  injCmd_t            cmd;

  addrMatcher #(.COL_W(COL_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W)) u_match (
    .matchWord(actMatch),
    .care     (actCare),
    .threeDimm(threeDimm),
    .dimm     (wrDimm),
    .rank     (wrRank),
    .bank     (wrBank),
    .page     (wrPage),
    .col      (wrCol),
    .hit      (hit)
  );

  injCtrl #(.MATCH_W(MATCH_W), .ECC_W(ECC_W), .REG_W(REG_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .regWe   (regWe),
    .regSel  (regSel),
    .regWdata(regWdata),
    .wrStrobe(wrStrobe),
    .hit     (hit),
    .actMatch(actMatch),
    .actCare (actCare),
    .actFlip (actFlip),
    .armed   (armedOut),
    .cmd     (cmd)
  );

  injDatapath #(.ECC_W(ECC_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .wrStrobe (wrStrobe),
    .cmd      (cmd),
    .flipMask (actFlip),
    .eccLoIn  (eccLoIn),
    .eccHiIn  (eccHiIn),
    .eccLoOut (eccLoOut),
    .eccHiOut (eccHiOut),
    .parityBad(parityBad),
    .outValid (outValid)
  );

endmodule

// File: rtl/injChecker.sv
module injChecker
  import injPkg::*;
#(
  parameter int ECC_W = 32,
  parameter int REG_W = 37
) (
  input logic             clk,
  input logic             rst,
  input logic             regWe,
  input logic [1:0]       regSel,
  input logic [REG_W-1:0] regWdata,
  input logic             wrStrobe,
  input logic [ECC_W-1:0] eccLoIn,
  input logic [ECC_W-1:0] eccHiIn,
  input logic [ECC_W-1:0] eccLoOut,
  input logic [ECC_W-1:0] eccHiOut,
  input logic             parityBad,
  input logic             outValid,
  input logic             armedOut,
  input injCmd_t          cmd
);

  logic ctrlWr;
  assign ctrlWr = regWe && (regSel == SEL_CTRL);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!armedOut && !parityBad && !outValid));

  a_r2_arm: assert property (@(posedge clk) disable iff (rst)
    (ctrlWr && (regWdata[CTL_ECC] || regWdata[CTL_PAR])) |=> armedOut);

  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    (ctrlWr && !regWdata[CTL_ECC] && !regWdata[CTL_PAR]) |=> !armedOut);

  a_r12_idle_passthru: assert property (@(posedge clk) disable iff (rst)
    !wrStrobe |=> (!parityBad && !outValid &&
                   eccLoOut == $past(eccLoIn) && eccHiOut == $past(eccHiIn)));

  a_r8_parity_needs_arm: assert property (@(posedge clk) disable iff (rst)
    parityBad |-> ($past(armedOut) && $past(wrStrobe)));

  a_r9_disarm_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(armedOut) |-> $past(ctrlWr || cmd.flipLo || cmd.flipHi || cmd.parity));

endmodule

bind wrErrInjector injChecker #(.ECC_W(ECC_W), .REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .regWe    (regWe),
  .regSel   (regSel),
  .regWdata (regWdata),
  .wrStrobe (wrStrobe),
  .eccLoIn  (eccLoIn),
  .eccHiIn  (eccHiIn),
  .eccLoOut (eccLoOut),
  .eccHiOut (eccHiOut),
  .parityBad(parityBad),
  .outValid (outValid),
  .armedOut (armedOut),
  .cmd      (cmd)
);

// File: tb/sim_wrErrInjector.sv
module sim_wrErrInjector;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [36:0] regWdata = '0;
  logic        threeDimm = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [1:0]  wrDimm = '0;
  logic [1:0]  wrRank = '0;
  logic [3:0]  wrBank = '0;
  logic [15:0] wrPage = '0;
  logic [13:0] wrCol = '0;
  logic [31:0] eccLoIn = '0;
  logic [31:0] eccHiIn = '0;
  logic [31:0] eccLoOut, eccHiOut;
  logic        parityBad, outValid, armedOut;

  always #2 clk = ~clk;

  wrErrInjector u0 (
    .clk(clk), .rst(rst), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .threeDimm(threeDimm), .wrStrobe(wrStrobe), .wrDimm(wrDimm), .wrRank(wrRank),
    .wrBank(wrBank), .wrPage(wrPage), .wrCol(wrCol), .eccLoIn(eccLoIn),
    .eccHiIn(eccHiIn), .eccLoOut(eccLoOut), .eccHiOut(eccHiOut),
    .parityBad(parityBad), .outValid(outValid), .armedOut(armedOut)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] lo;
    logic [31:0] hi;
    logic        par;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  // reference model, from the requirements
  logic [36:0] sMatch = '0, aMatch = '0;
  logic [4:0]  sCare = '0, aCare = '0;
  logic [31:0] sFlip = '0, aFlip = '0;
  logic [4:0]  mCtrl = '0;
  bit          mArmed = 0;

  function automatic bit mHit(logic [1:0] d, logic [1:0] r, logic [3:0] b,
                              logic [15:0] p, logic [13:0] c, bit three);
    bit ok;
    ok = 1;
    if (aCare[0] && aMatch[13:0] != c) ok = 0;
    if (aCare[1] && aMatch[29:14] != p) ok = 0;
    if (aCare[2] && aMatch[33:30] != b) ok = 0;
    if (aCare[3]) begin
      if (three) begin
        if (aMatch[34] != r[0]) ok = 0;
      end else if (aMatch[35:34] != r) ok = 0;
    end
    if (aCare[4]) begin
      if (three) begin
        if (aMatch[36:35] != d) ok = 0;
      end else if (aMatch[36] != d[0]) ok = 0;
    end
    return ok;
  endfunction

  function automatic logic [36:0] mkMatch(logic [1:0] d, logic [1:0] r, logic [3:0] b,
                                          logic [15:0] p, logic [13:0] c, bit three);
    logic [36:0] w;
    w = '0;
    w[13:0]  = c;
    w[29:14] = p;
    w[33:30] = b;
    if (three) begin
      w[34]    = r[0];
      w[36:35] = d;
    end else begin
      w[35:34] = r;
      w[36]    = d[0];
    end
    return w;
  endfunction

  task automatic check1(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic regWrite(logic [1:0] sel, logic [36:0] data);
    @(negedge clk);
    wrStrobe = 1'b0;
    regWe    = 1'b1;
    regSel   = sel;
    regWdata = data;
    case (sel)
      2'd0: sMatch = data;
      2'd1: sCare  = data[4:0];
      2'd2: sFlip  = data[31:0];
      default: begin
        mCtrl  = data[4:0];
        mArmed = data[3] | data[4];
        if (mArmed) begin
          aMatch = sMatch;
          aCare  = sCare;
          aFlip  = sFlip;
        end
      end
    endcase
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // driver: one write per call, back-to-back when called in a row
  task automatic doWrite(logic [1:0] d, logic [1:0] r, logic [3:0] b, logic [15:0] p,
                         logic [13:0] c, bit three, logic [31:0] lo, logic [31:0] hi,
                         string tag);
    expItem_t it;
    bit fire;
    @(negedge clk);
    wrStrobe = 1'b1;
    wrDimm = d; wrRank = r; wrBank = b; wrPage = p; wrCol = c;
    threeDimm = three; eccLoIn = lo; eccHiIn = hi;
    fire   = mArmed && mHit(d, r, b, p, c, three);
    it.lo  = lo ^ ((fire && mCtrl[3] && mCtrl[1]) ? aFlip : 32'h0);
    it.hi  = hi ^ ((fire && mCtrl[3] && mCtrl[2]) ? aFlip : 32'h0);
    it.par = fire && mCtrl[4];
    it.tag = tag;
    expQ.push_back(it);
    if (fire && !mCtrl[0]) mArmed = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrStrobe = 1'b0;
    end
  endtask

  task automatic checkArmed(bit expv, string tag);
    check1(armedOut == expv, tag, 64'(armedOut), 64'(expv));
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        check1(0, "R12 unexpected output", 64'(outValid), 64'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check1(eccLoOut == e.lo, {e.tag, " lo"}, 64'(eccLoOut), 64'(e.lo));
        check1(eccHiOut == e.hi, {e.tag, " hi"}, 64'(eccHiOut), 64'(e.hi));
        check1(parityBad == e.par, {e.tag, " parity"}, 64'(parityBad), 64'(e.par));
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check1(!armedOut, "R1 armed after reset", 64'(armedOut), 0);
    check1(!outValid, "R1 outValid after reset", 64'(outValid), 0);
    check1(!parityBad, "R1 parity after reset", 64'(parityBad), 0);
    check1(eccLoOut == 0 && eccHiOut == 0, "R1 ecc after reset", {eccHiOut, eccLoOut}, 0);

    // R3 R7 R9 R6: all fields ignored, one-shot ECC on lower half
    regWrite(2'd2, 37'h0000_FFFF);
    regWrite(2'd3, 37'h0A);
    checkArmed(1, "R2 armed by ECC bit");
    doWrite(2'd3, 2'd2, 4'd9, 16'h1357, 14'h2AB, 0, 32'hA5A5_0F0F, 32'h1234_5678, "R3 R7 wildcard hit");
    doWrite(2'd3, 2'd2, 4'd9, 16'h1357, 14'h2AB, 0, 32'hA5A5_0F0F, 32'h1234_5678, "R9 second write clean");
    idle(1);
    checkArmed(0, "R9 disarmed after one-shot");

    // R10 R6 R7: repeat, both halves, multi-pair mask
    regWrite(2'd2, 37'hFF00_FF00);
    regWrite(2'd3, 37'h0F);
    doWrite(2'd0, 2'd0, 4'd0, 16'h0000, 14'h000, 0, 32'h0, 32'hFFFF_FFFF, "R10 repeat 1");
    doWrite(2'd1, 2'd3, 4'd7, 16'hFFFF, 14'h3FFF, 1, 32'h1111_1111, 32'h2222_2222, "R10 repeat 2");
    doWrite(2'd2, 2'd1, 4'd3, 16'h4242, 14'h0042, 0, 32'hDEAD_BEEF, 32'hCAFE_F00D, "R10 repeat 3");
    idle(1);
    checkArmed(1, "R10 still armed");
    regWrite(2'd3, 37'h00);
    checkArmed(0, "R2 cleared by zero write");
    doWrite(2'd2, 2'd1, 4'd3, 16'h4242, 14'h0042, 0, 32'hDEAD_BEEF, 32'hCAFE_F00D, "R2 after clear clean");
    idle(1);

    // R8 R6: parity only, half select 0
    regWrite(2'd3, 37'h11);
    doWrite(2'd1, 2'd1, 4'd1, 16'h0001, 14'h0001, 0, 32'h0F0F_0F0F, 32'hF0F0_F0F0, "R8 parity neither half");
    idle(1);

    // R4: column, page, bank compared
    regWrite(2'd0, mkMatch(2'd0, 2'd0, 4'd5, 16'hBEEF, 14'h0123, 0));
    regWrite(2'd1, 37'b00111);
    regWrite(2'd2, 37'h0000_0003);
    regWrite(2'd3, 37'h0D);
    doWrite(2'd0, 2'd0, 4'd5, 16'hBEEF, 14'h0123, 0, 32'h10, 32'h20, "R4 all fields match");
    doWrite(2'd0, 2'd0, 4'd5, 16'hBEEF, 14'h0124, 0, 32'h10, 32'h20, "R4 column miss");
    doWrite(2'd0, 2'd0, 4'd5, 16'hBEEE, 14'h0123, 0, 32'h10, 32'h20, "R4 page miss");
    doWrite(2'd0, 2'd0, 4'd4, 16'hBEEF, 14'h0123, 0, 32'h10, 32'h20, "R4 bank miss");
    doWrite(2'd1, 2'd3, 4'd5, 16'hBEEF, 14'h0123, 0, 32'h10, 32'h20, "R4 rank ignored hit");
    idle(1);

    // R5: DIMM/rank layout follows population
    regWrite(2'd0, 37'h14_0000_0000);
    regWrite(2'd1, 37'b11000);
    regWrite(2'd3, 37'h0B);
    doWrite(2'd2, 2'd1, 4'd0, 16'h0, 14'h0, 1, 32'h55, 32'h66, "R5 three-dimm hit");
    doWrite(2'd2, 2'd1, 4'd0, 16'h0, 14'h0, 0, 32'h55, 32'h66, "R5 two-dimm miss");
    doWrite(2'd1, 2'd1, 4'd0, 16'h0, 14'h0, 0, 32'h55, 32'h66, "R5 two-dimm hit");
    doWrite(2'd1, 2'd0, 4'd0, 16'h0, 14'h0, 1, 32'h55, 32'h66, "R5 three-dimm miss");
    idle(1);

    // R11: staged flip mask waits for arming write
    regWrite(2'd2, 37'hFFFF_0000);
    doWrite(2'd2, 2'd1, 4'd0, 16'h0, 14'h0, 1, 32'h0, 32'h0, "R11 old mask kept");
    idle(1);
    regWrite(2'd3, 37'h0B);
    doWrite(2'd2, 2'd1, 4'd0, 16'h0, 14'h0, 1, 32'h0, 32'h0, "R11 new mask after arm");
    idle(1);

    // R12: idle cycles do not consume a one-shot arm
    regWrite(2'd1, 37'b00000);
    regWrite(2'd3, 37'h0A);
    idle(4);
    checkArmed(1, "R12 idle keeps arm");
    doWrite(2'd0, 2'd0, 4'd0, 16'h0, 14'h0, 0, 32'h0, 32'h0, "R12 first write injected");
    idle(1);
    checkArmed(0, "R9 disarmed again");
    idle(3);

    check1(expQ.size() == 0, "R12 outputs pending", 64'(expQ.size()), 0);
    finishRun();
  end

endmodule